// File: doc/BRIEF.md
# Software Store/Recall Sequence Detector

This block sits beside an SRAM that has a nonvolatile shadow copy. It watches completed bus cycles on the 13-bit address bus. It looks for a fixed unlock pattern of six read addresses. The first five addresses are shared. The sixth address selects the command: a STORE (copy the SRAM into the nonvolatile cells), a RECALL (copy the nonvolatile cells back into the SRAM), or a reserved test code. The test code is flagged but never acts as a command. The memory array and the cell transfer timing belong to other blocks.

A one-clock strobe marks the end of each bus cycle. Only strobed cycles with chip enable asserted count. Such a cycle is a read when write enable is high and a write when it is low. Output enable plays no part in recognition. It only gates the data-drive enable that this block hands to the data-bus pads. During the sixth cycle of a valid STORE or RECALL pattern, that drive enable is held off so the data pins float.

Top module: `ssr_seq_detect`

## Requirements
- R1: Strobed reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F on six consecutive counted cycles raise `store_o` in the clock after the strobe of the last one.
- R2: The same five-address prefix followed by 0x0F0E raises `recall_o` in the clock after the final strobe.
- R3: The prefix followed by 0x139C raises `test_o` and neither `store_o` nor `recall_o`, and the detector returns to idle.
- R4: A read address that does not continue the pattern returns the detector to idle. If that address is 0x0000, it counts as the first step of a new attempt.
- R5: A counted write cycle (`we_ni` low) aborts any progress and issues no command.
- R6: Strobed cycles with `ce_ni` high leave the progress unchanged and issue no command.
- R7: The level of `oe_ni` has no effect on recognition or on the command outputs.
- R8: `data_drive_o` equals chip enable AND output enable AND write enable high (all active-low inputs taken as asserted when low), except that it is low while the detector has matched the full prefix and the bus shows a read of 0x0F0F or 0x0F0E with chip enable asserted.
- R9: `store_o`, `recall_o` and `test_o` are single-clock pulses, and at most one of them is high at a time.
- R10: While `rst_ni` is low, all command outputs are low and the detector is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_i | input | 1 | One-clock strobe marking the end of a bus cycle |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 13 | Address of the current bus cycle |
| store_o | output | 1 | STORE command pulse |
| recall_o | output | 1 | RECALL command pulse |
| test_o | output | 1 | Reserved test pattern flag pulse |
| data_drive_o | output | 1 | Data-bus drive enable; low floats the data pins |

## Verification
Directed runs apply the complete STORE, RECALL and test patterns. These show that the sixth address alone selects the command. The same STORE pattern is then replayed with output enable high and with deselected cycles placed in the middle, to show that neither disturbs progress. Broken patterns separate a plain mismatch (back to idle) from a mismatch on 0x0000 (new first step), and a write in mid-pattern shows the abort. Constrained random cycles weighted toward the next expected address then exercise many partial and overlapping attempts. Each one is checked against a bench model of the step count and of the drive enable.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int ADDR_W     = 13;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2,
    CMD_TEST   = 2'd3
  } cmd_e;

  localparam addr_t STORE_ADDR  = 13'h0F0F;
  localparam addr_t RECALL_ADDR = 13'h0F0E;
  localparam addr_t TEST_ADDR   = 13'h139C;

  function automatic addr_t prefix_addr(input int idx);
    case (idx)
      0:       return 13'h0000;
      1:       return 13'h1555;
      2:       return 13'h0AAA;
      3:       return 13'h1FFF;
      4:       return 13'h10F0;
      default: return 13'h0000;
    endcase
  endfunction
endpackage

// File: rtl/ssr_prefix_match.sv
module ssr_prefix_match
  import ssr_pkg::*;
(
  input  addr_t                 addr_i,
  output logic [PREFIX_LEN-1:0] hit_o
);
  for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_cmp
    assign hit_o[g] = (addr_i == prefix_addr(g));
  end
endmodule

// File: rtl/ssr_term_decode.sv
module ssr_term_decode
  import ssr_pkg::*;
(
  input  addr_t addr_i,
  output cmd_e  cmd_o
);
  always_comb begin
    unique case (addr_i)
      STORE_ADDR:  cmd_o = CMD_STORE;
      RECALL_ADDR: cmd_o = CMD_RECALL;
      TEST_ADDR:   cmd_o = CMD_TEST;
      default:     cmd_o = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/ssr_step_tracker.sv
module ssr_step_tracker
  import ssr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic [PREFIX_LEN-1:0] hit_i,
  output step_t                 step_o,
  output logic                  full_o
);
  step_t step_q, step_d;
  logic  step_hit;

  // hit for the address the current step expects
  always_comb begin
    step_hit = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (step_q == step_t'(i)) step_hit = hit_i[i];
    end
  end

  always_comb begin
    step_d = step_q;
    if (wr_i) begin
      step_d = '0;
    end else if (rd_i) begin
      if (step_hit)      step_d = step_q + step_t'(1);
      else if (hit_i[0]) step_d = step_t'(1);  // 0000 restarts the attempt
      else               step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  assign step_o = step_q;
  assign full_o = (step_q == step_t'(PREFIX_LEN));
endmodule

// File: rtl/ssr_seq_detect.sv
module ssr_seq_detect
  import ssr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cycle_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              store_o,
  output logic              recall_o,
  output logic              test_o,
  output logic              data_drive_o
);
  logic [PREFIX_LEN-1:0] hit;
  cmd_e                  term_cmd;
  step_t                 step;
  logic                  full;
  logic                  rd_cyc, wr_cyc, fire, float_bus;
  logic                  store_q, recall_q, test_q;

  assign rd_cyc = cycle_i & ~ce_ni & we_ni;
  assign wr_cyc = cycle_i & ~ce_ni & ~we_ni;

  ssr_prefix_match u_match (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  ssr_term_decode u_term (
    .addr_i (addr_i),
    .cmd_o  (term_cmd)
  );

  ssr_step_tracker u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_cyc),
    .wr_i   (wr_cyc),
    .hit_i  (hit),
    .step_o (step),
    .full_o (full)
  );

  assign fire = rd_cyc & full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q  <= 1'b0;
      recall_q <= 1'b0;
      test_q   <= 1'b0;
    end else begin
      store_q  <= fire & (term_cmd == CMD_STORE);
      recall_q <= fire & (term_cmd == CMD_RECALL);
      test_q   <= fire & (term_cmd == CMD_TEST);
    end
  end

  // final cycle floats the bus whatever the strobe or oe level
  assign float_bus    = full & ~ce_ni & we_ni &
                        ((term_cmd == CMD_STORE) | (term_cmd == CMD_RECALL));
  assign data_drive_o = ~ce_ni & ~oe_ni & we_ni & ~float_bus;

  assign store_o  = store_q;
  assign recall_o = recall_q;
  assign test_o   = test_q;
endmodule

// File: rtl/ssr_seq_detect_chk.sv
module ssr_seq_detect_chk
  import ssr_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  cycle_i,
  input logic  ce_ni,
  input logic  we_ni,
  input addr_t addr_i,
  input logic  store_o,
  input logic  recall_o,
  input logic  test_o,
  input logic  data_drive_o,
  input step_t step_i
);
  p_store_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> $past(cycle_i && !ce_ni && we_ni && addr_i == STORE_ADDR
                      && step_i == step_t'(PREFIX_LEN)));

  p_recall_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |-> $past(cycle_i && !ce_ni && we_ni && addr_i == RECALL_ADDR
                       && step_i == step_t'(PREFIX_LEN)));

  p_test_no_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_i && !ce_ni && we_ni && addr_i == TEST_ADDR)
    |=> (!store_o && !recall_o && step_i == '0));

  p_zero_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_i && !ce_ni && we_ni && addr_i == '0) |=> (step_i == step_t'(1)));

  p_step_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i <= step_t'(PREFIX_LEN));

  p_write_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_i && !ce_ni && !we_ni)
    |=> (step_i == '0 && !store_o && !recall_o && !test_o));

  p_deselect_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_i && ce_ni) |=> ($stable(step_i) && !store_o && !recall_o && !test_o));

  p_final_float_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == step_t'(PREFIX_LEN) && !ce_ni && we_ni
     && (addr_i == STORE_ADDR || addr_i == RECALL_ADDR)) |-> !data_drive_o);

  p_onehot_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_o, recall_o, test_o}));

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o || recall_o || test_o) |=> !(store_o || recall_o || test_o));
endmodule

bind ssr_seq_detect ssr_seq_detect_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cycle_i      (cycle_i),
  .ce_ni        (ce_ni),
  .we_ni        (we_ni),
  .addr_i       (addr_i),
  .store_o      (store_o),
  .recall_o     (recall_o),
  .test_o       (test_o),
  .data_drive_o (data_drive_o),
  .step_i       (step)
);

// File: tb/ssr_seq_detect_tb.sv
module ssr_seq_detect_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cycle_i = 1'b0;
  logic        ce_ni = 1'b1;
  logic        we_ni = 1'b1;
  logic        oe_ni = 1'b1;
  logic [12:0] addr_i = '0;
  logic        store_o, recall_o, test_o, data_drive_o;

  int n_chk = 0;
  int n_fail = 0;
  int m_step = 0;  // bench model of progress

  always #2 clk_i = ~clk_i;

  ssr_seq_detect u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cycle_i      (cycle_i),
    .ce_ni        (ce_ni),
    .we_ni        (we_ni),
    .oe_ni        (oe_ni),
    .addr_i       (addr_i),
    .store_o      (store_o),
    .recall_o     (recall_o),
    .test_o       (test_o),
    .data_drive_o (data_drive_o)
  );

  function automatic logic [12:0] pat(input int i);
    logic [12:0] t [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};
    return t[i];
  endfunction

  // expected {store,recall,test} for a strobed cycle
  function automatic logic [2:0] exp_cmd(input int st, input logic [12:0] a,
                                         input logic ce_n, input logic we_n);
    if (ce_n || !we_n || st != 5) return 3'b000;
    if (a == 13'h0F0F) return 3'b100;
    if (a == 13'h0F0E) return 3'b010;
    if (a == 13'h139C) return 3'b001;
    return 3'b000;
  endfunction

  function automatic int exp_step(input int st, input logic [12:0] a,
                                  input logic ce_n, input logic we_n);
    if (ce_n) return st;
    if (!we_n) return 0;
    if (st < 5 && a == pat(st)) return st + 1;
    return (a == 13'h0000) ? 1 : 0;
  endfunction

  function automatic logic exp_drive(input int st, input logic [12:0] a,
                                     input logic ce_n, input logic we_n, input logic oe_n);
    logic fl;
    fl = (st == 5) && !ce_n && we_n && (a == 13'h0F0F || a == 13'h0F0E);
    return !ce_n && !oe_n && we_n && !fl;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus(input logic [12:0] a, input logic ce_n, input logic we_n,
                     input logic oe_n, input string tag);
    logic [2:0] ec;
    @(negedge clk_i);
    addr_i = a; ce_ni = ce_n; we_ni = we_n; oe_ni = oe_n; cycle_i = 1'b1;
    #1;
    chk("R8 drive", 32'(data_drive_o), 32'(exp_drive(m_step, a, ce_n, we_n, oe_n)));
    ec = exp_cmd(m_step, a, ce_n, we_n);
    m_step = exp_step(m_step, a, ce_n, we_n);
    @(posedge clk_i); #1;
    chk(tag, 32'({store_o, recall_o, test_o}), 32'(ec));
    @(negedge clk_i);
    cycle_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R9 pulse ends", 32'({store_o, recall_o, test_o}), 32'd0);
  endtask

  task automatic prefix(input logic oe_n);
    for (int i = 0; i < 5; i++) bus(pat(i), 1'b0, 1'b1, oe_n, "R1 prefix quiet");
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [12:0] a;
    logic        c, w, o;
    int          r;
    void'($urandom(32'd7741));
    #9;
    chk("R10 reset cmds", 32'({store_o, recall_o, test_o}), 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;

    prefix(1'b0); bus(13'h0F0F, 1'b0, 1'b1, 1'b0, "R1 store");
    prefix(1'b0); bus(13'h0F0E, 1'b0, 1'b1, 1'b0, "R2 recall");
    prefix(1'b0); bus(13'h139C, 1'b0, 1'b1, 1'b0, "R3 test flag");
    bus(13'h0F0F, 1'b0, 1'b1, 1'b0, "R3 idle after test");
    // oe deasserted throughout
    prefix(1'b1); bus(13'h0F0F, 1'b0, 1'b1, 1'b1, "R7 store oe high");
    // write in mid-pattern
    bus(13'h0000, 1'b0, 1'b1, 1'b0, "R5 step");
    bus(13'h1555, 1'b0, 1'b1, 1'b0, "R5 step");
    bus(13'h0AAA, 1'b0, 1'b0, 1'b0, "R5 write");
    bus(13'h1FFF, 1'b0, 1'b1, 1'b0, "R5 after abort");
    bus(13'h10F0, 1'b0, 1'b1, 1'b0, "R5 after abort");
    bus(13'h0F0F, 1'b0, 1'b1, 1'b0, "R5 no store");
    // deselected cycles inside the pattern
    bus(13'h0000, 1'b0, 1'b1, 1'b0, "R6 step");
    bus(13'h0F0F, 1'b1, 1'b1, 1'b0, "R6 deselect");
    bus(13'h1555, 1'b0, 1'b1, 1'b0, "R6 step");
    bus(13'h0AAA, 1'b0, 1'b1, 1'b0, "R6 step");
    bus(13'h1FFF, 1'b0, 1'b1, 1'b0, "R6 step");
    bus(13'h10F0, 1'b0, 1'b1, 1'b0, "R6 step");
    bus(13'h0F0E, 1'b1, 1'b1, 1'b0, "R6 deselect final");
    bus(13'h0F0F, 1'b0, 1'b1, 1'b0, "R6 store kept");
    // mismatch and restart on 0000
    bus(13'h0000, 1'b0, 1'b1, 1'b0, "R4 step");
    bus(13'h1555, 1'b0, 1'b1, 1'b0, "R4 step");
    bus(13'h0000, 1'b0, 1'b1, 1'b0, "R4 restart");
    bus(13'h1555, 1'b0, 1'b1, 1'b0, "R4 step");
    bus(13'h0AAA, 1'b0, 1'b1, 1'b0, "R4 step");
    bus(13'h1FFF, 1'b0, 1'b1, 1'b0, "R4 step");
    bus(13'h10F0, 1'b0, 1'b1, 1'b0, "R4 step");
    bus(13'h0F0E, 1'b0, 1'b1, 1'b0, "R4 recall after restart");
    prefix(1'b0); bus(13'h0AAA, 1'b0, 1'b1, 1'b0, "R4 mismatch final");
    bus(13'h0F0F, 1'b0, 1'b1, 1'b0, "R4 idle after mismatch");

    for (int k = 0; k < 3000; k++) begin
      r = int'($urandom % 8);
      if (r < 5) begin
        if (m_step < 5) a = pat(m_step);
        else begin
          case ($urandom % 3)
            0: a = 13'h0F0F;
            1: a = 13'h0F0E;
            default: a = 13'h139C;
          endcase
        end
      end else if (r == 5) a = 13'h0000;
      else a = 13'($urandom);
      c = ($urandom % 10) == 0;
      w = ($urandom % 20) != 0;
      o = $urandom % 2;
      bus(a, c, w, o, "R1 R2 R3 random cmd");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule